// File: doc/BRIEF.md
# Interrupt Pending-State and Priority Arbiter

This block keeps the per-source interrupt state for a fixed set of identifiers: an enable bit, a pending bit and the last sampled level of each external line. The external lines are sampled every clock. A rising line marks its source pending according to that source's trigger mode. A separate register bank outside the block can set or clear single pending and enable bits through strobe vectors. It also supplies the trigger mode of each source and its 8-bit priority.

Each cycle a combinational scan picks the enabled, pending source with the most urgent priority, where a smaller value is more urgent. The result is qualified by two enables, a priority mask and the priority of the interrupt now being serviced. The block then registers a single request to the processor and the identifier of the winning source. When nothing qualifies, it reports a fixed spurious identifier.

Top module: `irq_arb_top`

## Requirements
- R1: While synchronous reset is high, every enable, pending and stored-level bit clears, `irq_req` is 0 and `best_id` reads 1023.
- R2: External line n belongs to identifier n+32. A 0-to-1 change on the line of an edge-mode source (`trig_edge` bit = 1) sets its pending bit, even when the source is disabled.
- R3: A rising line on a level-mode source (`trig_edge` bit = 0) sets pending only if that source is enabled; on a disabled level-mode source the rise leaves pending at 0.
- R4: Setting the enable of a level-mode source whose stored line level is 1 also sets its pending bit.
- R5: `set_pend`/`clr_pend` and `set_en`/`clr_en` change single bits one clock later; when set and clear strobe the same bit in one cycle, the bit ends up set.
- R6: Among enabled and pending sources the one with the smallest priority value wins; on equal values the lowest identifier wins.
- R7: With no source both enabled and pending, `best_id` is 1023 and `irq_req` is 0.
- R8: If `dist_en` or `cpu_en` is 0, `irq_req` is 0 and `best_id` is 1023.
- R9: If the winning priority is numerically greater than `prio_mask`, `irq_req` is 0 and `best_id` is 1023; a priority equal to the mask still passes.
- R10: `irq_req` is 1 only when the winning priority is strictly below `run_prio` (256 means nothing is running); otherwise the winner's identifier is still reported on `best_id`.
- R11: `irq_req` and `best_id` are registered: they reflect the state bits one clock after those bits change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq | input | 64 | External interrupt lines, line n is identifier n+32 |
| trig_edge | input | 96 | Per-source trigger mode, 1 = edge, 0 = level |
| prio_flat | input | 768 | Per-source priority, byte i is identifier i |
| set_pend | input | 96 | Set-pending strobes |
| clr_pend | input | 96 | Clear-pending strobes |
| set_en | input | 96 | Set-enable strobes |
| clr_en | input | 96 | Clear-enable strobes |
| dist_en | input | 1 | Global distribution enable |
| cpu_en | input | 1 | Processor-interface enable |
| prio_mask | input | 9 | Priority mask, winners above it are blocked |
| run_prio | input | 9 | Priority of the interrupt being serviced, 256 when idle |
| pend_state | output | 96 | Current pending bits |
| en_state | output | 96 | Current enable bits |
| irq_req | output | 1 | Registered interrupt request to the processor |
| best_id | output | 10 | Registered identifier of the winning source, 1023 if none |

## Verification
Table vectors place two sources against each other with chosen priorities, mask and running priority. These vectors separate a plain priority win from a tie broken by identifier. They also separate a mask equality that passes from one step over it that blocks, and a running priority equal to the winner, which suppresses only the request, from one just above it. The extreme identifiers 0 and 95 are paired to catch a scan that stops short. Directed patterns drive the external lines with each trigger mode and with the source enabled or disabled, distinguishing edge capture, gated level capture and capture on enable. Further patterns check the same-cycle set/clear conflict, each enable alone gating the request, an empty selection, and the one-cycle output lag.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef struct packed {
    logic              found;
    logic [ID_W-1:0]   id;
    logic [PRIO_W-1:0] prio;
  } pick_t;
endpackage

// File: rtl/irq_src_state.sv
module irq_src_state #(
  parameter int NUM_ID   = 96,
  parameter int EXT_BASE = 32,
  localparam int NUM_EXT = NUM_ID - EXT_BASE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EXT-1:0] ext_irq,
  input  logic [NUM_ID-1:0] trig_edge,
  input  logic [NUM_ID-1:0] set_pend,
  input  logic [NUM_ID-1:0] clr_pend,
  input  logic [NUM_ID-1:0] set_en,
  input  logic [NUM_ID-1:0] clr_en,
  output logic [NUM_ID-1:0] pend_q,
  output logic [NUM_ID-1:0] en_q
);
  logic [NUM_ID-1:0] lvl_q;
  logic [NUM_ID-1:0] line_in;
  logic [NUM_ID-1:0] hw_set;

  // Map external lines onto the upper identifiers; the lower ones have no line.
  assign line_in = {ext_irq, {EXT_BASE{1'b0}}};

  for (genvar i = 0; i < NUM_ID; i++) begin : g_src
    logic rise;
    assign rise = line_in[i] & ~lvl_q[i];
    // Edge sources always capture; level sources only when enabled, or when
    // being enabled while their line is already high.
    assign hw_set[i] = (rise & (trig_edge[i] | en_q[i]))
                     | (set_en[i] & lvl_q[i] & ~trig_edge[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_q[i]  <= 1'b0;
        pend_q[i] <= 1'b0;
        en_q[i]   <= 1'b0;
      end else begin
        lvl_q[i]  <= line_in[i];
        pend_q[i] <= (pend_q[i] & ~clr_pend[i]) | set_pend[i] | hw_set[i];
        en_q[i]   <= (en_q[i] & ~clr_en[i]) | set_en[i];
      end
    end

    assert_edge_capture_R2: assert property (@(posedge clk) disable iff (rst)
      (line_in[i] && !lvl_q[i] && trig_edge[i]) |=> pend_q[i]);
    assert_level_enable_R4: assert property (@(posedge clk) disable iff (rst)
      (set_en[i] && lvl_q[i] && !trig_edge[i]) |=> (pend_q[i] && en_q[i]));
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
      (set_pend[i] && clr_pend[i]) |=> pend_q[i]);
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_arb_pkg::*;
#(
  parameter int NUM_ID = 96
) (
  input  logic [NUM_ID-1:0]        eligible,
  input  logic [NUM_ID*PRIO_W-1:0] prio_flat,
  output pick_t                    pick
);
  always_comb begin
    pick.found = 1'b0;
    pick.id    = SPURIOUS_ID;
    pick.prio  = '1;
    // Ascending scan with a strict compare keeps the lowest id on ties.
    for (int i = 0; i < NUM_ID; i++) begin
      if (eligible[i] &&
          (!pick.found || (prio_flat[i*PRIO_W +: PRIO_W] < pick.prio))) begin
        pick.found = 1'b1;
        pick.id    = ID_W'(i);
        pick.prio  = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
  import irq_arb_pkg::*;
#(
  parameter int NUM_ID   = 96,
  parameter int EXT_BASE = 32,
  localparam int NUM_EXT = NUM_ID - EXT_BASE
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_EXT-1:0]        ext_irq,
  input  logic [NUM_ID-1:0]         trig_edge,
  input  logic [NUM_ID*PRIO_W-1:0]  prio_flat,
  input  logic [NUM_ID-1:0]         set_pend,
  input  logic [NUM_ID-1:0]         clr_pend,
  input  logic [NUM_ID-1:0]         set_en,
  input  logic [NUM_ID-1:0]         clr_en,
  input  logic                      dist_en,
  input  logic                      cpu_en,
  input  logic [PRIO_W:0]           prio_mask,
  input  logic [PRIO_W:0]           run_prio,
  output logic [NUM_ID-1:0]         pend_state,
  output logic [NUM_ID-1:0]         en_state,
  output logic                      irq_req,
  output logic [ID_W-1:0]           best_id
);
  pick_t pick;
  logic  pass_mask;
  logic  req_d;
  logic [ID_W-1:0] id_d;

  irq_src_state #(.NUM_ID(NUM_ID), .EXT_BASE(EXT_BASE)) u_state (
    .clk(clk), .rst(rst), .ext_irq(ext_irq), .trig_edge(trig_edge),
    .set_pend(set_pend), .clr_pend(clr_pend), .set_en(set_en), .clr_en(clr_en),
    .pend_q(pend_state), .en_q(en_state)
  );

  irq_prio_pick #(.NUM_ID(NUM_ID)) u_pick (
    .eligible(pend_state & en_state), .prio_flat(prio_flat), .pick(pick)
  );

  always_comb begin
    pass_mask = pick.found && ({1'b0, pick.prio} <= prio_mask);
    req_d     = 1'b0;
    id_d      = SPURIOUS_ID;
    if (dist_en && cpu_en && pass_mask) begin
      id_d  = pick.id;
      req_d = {1'b0, pick.prio} < run_prio;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      best_id <= SPURIOUS_ID;
    end else begin
      irq_req <= req_d;
      best_id <= id_d;
    end
  end

  assert_gate_off_R8: assert property (@(posedge clk) disable iff (rst)
    (!dist_en || !cpu_en) |=> (!irq_req && best_id == SPURIOUS_ID));
  assert_spurious_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (best_id == SPURIOUS_ID) |-> !irq_req);
  assert_empty_sel_R7: assert property (@(posedge clk) disable iff (rst)
    ((pend_state & en_state) == '0) |=> (best_id == SPURIOUS_ID));
  assert_req_below_run_R10: assert property (@(posedge clk) disable iff (rst)
    (run_prio == '0) |=> !irq_req);
endmodule

// File: tb/sim_irq_arb_top.sv
module sim_irq_arb_top;
  localparam int NID = 96;
  localparam int NEXT = 64;

  typedef struct packed {
    logic [6:0] ida; logic [7:0] pa;
    logic [6:0] idb; logic [7:0] pb;
    logic [8:0] mask; logic [8:0] run;
    logic [9:0] exp_id; logic exp_req;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{7'd50, 8'h30, 7'd60, 8'h10, 9'h0F0, 9'h100, 10'd60,   1'b1}, // R6 smaller wins
    '{7'd40, 8'h20, 7'd35, 8'h20, 9'h0F0, 9'h100, 10'd35,   1'b1}, // R6 tie low id
    '{7'd10, 8'h80, 7'd11, 8'h90, 9'h080, 9'h100, 10'd10,   1'b1}, // R9 equal passes
    '{7'd10, 8'h81, 7'd11, 8'h90, 9'h080, 9'h100, 10'd1023, 1'b0}, // R9 over mask
    '{7'd5,  8'h40, 7'd6,  8'h50, 9'h0F0, 9'h040, 10'd5,    1'b0}, // R10 equal run
    '{7'd5,  8'h40, 7'd6,  8'h50, 9'h0F0, 9'h041, 10'd5,    1'b1}, // R10 below run
    '{7'd0,  8'h70, 7'd95, 8'h6F, 9'h0F0, 9'h100, 10'd95,   1'b1}  // R6 ends of range
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [NEXT-1:0] ext_irq = '0;
  logic [NID-1:0] trig_edge = '0, set_pend = '0, clr_pend = '0, set_en = '0, clr_en = '0;
  logic [NID*8-1:0] prio_flat = '1;
  logic dist_en = 1'b0, cpu_en = 1'b0;
  logic [8:0] prio_mask = 9'h0F0, run_prio = 9'h100;
  logic [NID-1:0] pend_state, en_state;
  logic irq_req;
  logic [9:0] best_id;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  irq_arb_top u0 (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic strobe(ref logic [NID-1:0] sig, input int id);
    sig[id] = 1'b1;
    @(negedge clk);
    sig = '0;
  endtask

  task automatic clear_all();
    clr_pend = '1; clr_en = '1;
    @(negedge clk);
    clr_pend = '0; clr_en = '0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq_req", irq_req, 0);
    check("R1 best_id", best_id, 1023);
    check("R1 pend", pend_state == '0, 1);
    check("R1 en", en_state == '0, 1);
    rst = 1'b0; dist_en = 1'b1; cpu_en = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      clear_all();
      prio_flat = '1;
      prio_flat[TBL[v].ida*8 +: 8] = TBL[v].pa;
      prio_flat[TBL[v].idb*8 +: 8] = TBL[v].pb;
      prio_mask = TBL[v].mask; run_prio = TBL[v].run;
      set_pend[TBL[v].ida] = 1; set_pend[TBL[v].idb] = 1;
      set_en[TBL[v].ida] = 1;   set_en[TBL[v].idb] = 1;
      @(negedge clk);
      set_pend = '0; set_en = '0;
      @(negedge clk);
      check($sformatf("R6/R9/R10 vec%0d id", v), best_id, TBL[v].exp_id);
      check($sformatf("R6/R9/R10 vec%0d req", v), irq_req, TBL[v].exp_req);
    end
    prio_mask = 9'h0F0; run_prio = 9'h100; prio_flat = '1;

    // R7: nothing eligible (pending but disabled)
    clear_all();
    strobe(set_pend, 20);
    @(negedge clk);
    check("R7 id", best_id, 1023);
    check("R7 req", irq_req, 0);

    // R2: line 3 -> id 35, edge mode, disabled
    clear_all();
    trig_edge[35] = 1; ext_irq[3] = 1;
    @(negedge clk);
    check("R2 edge pend id35", pend_state[35], 1);
    check("R2 no other", pend_state == (96'd1 << 35), 1);
    ext_irq = '0; trig_edge = '0;

    // R3: level mode, disabled, rise ignored
    clear_all();
    ext_irq[10] = 1;
    @(negedge clk);
    @(negedge clk);
    check("R3 disabled level ignored", pend_state[42], 0);
    // R4: enabling while held high sets pending
    strobe(set_en, 42);
    check("R4 enable sets pend", pend_state[42], 1);
    ext_irq = '0;
    // R3: enabled level rise captured
    clear_all();
    strobe(set_en, 44);
    ext_irq[12] = 1;
    @(negedge clk);
    check("R3 enabled level captured", pend_state[44], 1);
    ext_irq = '0;

    // R5: set and clear together -> set
    clear_all();
    set_pend[7] = 1; clr_pend[7] = 1; set_en[7] = 1; clr_en[7] = 1;
    @(negedge clk);
    set_pend = '0; clr_pend = '0; set_en = '0; clr_en = '0;
    check("R5 pend set wins", pend_state[7], 1);
    check("R5 en set wins", en_state[7], 1);
    strobe(clr_pend, 7);
    check("R5 clear", pend_state[7], 0);

    // R11: output lags state by one clock
    prio_flat[7*8 +: 8] = 8'h10;
    strobe(set_pend, 7);
    check("R11 state first", pend_state[7], 1);
    check("R11 output not yet", best_id, 1023);
    @(negedge clk);
    check("R11 output next", best_id, 7);
    check("R11 req next", irq_req, 1);

    // R8: each enable alone blocks
    dist_en = 0;
    @(negedge clk);
    check("R8 dist off req", irq_req, 0);
    check("R8 dist off id", best_id, 1023);
    dist_en = 1; cpu_en = 0;
    @(negedge clk);
    check("R8 cpu off req", irq_req, 0);
    cpu_en = 1;
    @(negedge clk);
    check("R8 restored", irq_req, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule